// File: doc/BRIEF.md
# Advertising Packet Receiver with Serial Output

This block takes a stream of demodulated one-bit samples and recovers Bluetooth Low Energy advertising packets from it. Samples arrive one per clock, with a fixed number of samples per symbol. The block searches every sample phase at once for the 40-symbol sync word: a preamble followed by the advertising access address. When it finds the word, it locks to the phase that matched and takes one symbol per symbol period from then on.

Each locked symbol is dewhitened with a 7-bit LFSR that is seeded from the channel index. The symbols are then assembled into the two-byte PDU header, the payload and the 24-bit CRC. Payload bytes are written into an inferred RAM as they complete. If the CRC residue is zero, the stored bytes are sent out in order as 8N1 serial frames. If the CRC fails, the packet is dropped without output.

Top module: `adv_rx`

## Requirements
- R1: Out of reset, and whenever no frame is being sent, `uart_tx_o` is held at 1.
- R2: Lock needs 40 consecutive symbols that equal 0xAA followed by 0x8E89BED6, each sent LSB first. The first symbol on air is 0. Any other preamble or address gives no output.
- R3: After the match, one symbol is taken every OSR samples, at the sample phase that matched. The alignment of the packet to the sample counter has no effect.
- R4: Every symbol after the access address is XORed with bit 0 of a 7-bit register s. The register is loaded with s[6]=1 and s[5:0]=chan_i. After each symbol, s6'=s0, s2'=s3^s0, and every other bit takes the value of the bit above it.
- R5: The PDU begins with two header bytes, sent LSB first. The second byte is the payload length in bytes. A length above DEPTH drops the packet.
- R6: The CRC register starts at 0x555555. For each dewhitened bit b, with f=crc[23]^b, it shifts left and is XORed with 0x00065B when f=1. The 24 received CRC bits (register bit 23 first) run through the same update, and the packet is accepted only when the register ends at zero. A rejected packet produces no output.
- R7: An accepted packet's payload bytes leave `uart_tx_o` in the order received. Each byte is one frame: a low start bit, 8 data bits LSB first and a high stop bit, each CLKS_PER_BAUD clocks long.
- R8: An accepted packet with length 0 produces no serial output, and reception continues afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock, one sample per cycle |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sample_i | input | 1 | Demodulated one-bit sample |
| chan_i | input | 6 | Channel index that seeds the dewhitening LFSR |
| uart_tx_o | output | 1 | Serial output line |

## Verification
The bench builds the block with OSR=4, DEPTH=8 and CLKS_PER_BAUD=4. This keeps a whole packet and its serial drain within a few hundred cycles. At that size the bench can sweep every legal length from 0 to DEPTH, every sample phase and several channel seeds. It also covers the boundary one byte past DEPTH, a corrupted CRC, a corrupted address and the inverted preamble.

// File: rtl/adv_pkg.sv
package adv_pkg;
  localparam int unsigned SYNC_LEN = 40;
  // preamble in [7:0], address in [39:8]; bit 0 is first on air
  localparam logic [SYNC_LEN-1:0] SYNC_WORD = {32'h8E89BED6, 8'hAA};
  localparam logic [23:0] CRC_INIT = 24'h555555;
  localparam logic [23:0] CRC_POLY = 24'h00065B;

  typedef enum logic [2:0] {
    ST_HUNT, ST_HDR, ST_BODY, ST_CRC, ST_SEND
  } adv_state_e;
endpackage

// File: rtl/adv_sync.sv
module adv_sync #(
  parameter int unsigned OSR = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sample_i,
  input  logic en_i,
  output logic hit_o
);
  import adv_pkg::*;
  localparam int unsigned PW = (OSR > 1) ? $clog2(OSR) : 1;

  logic [PW-1:0] ph_q;
  logic [SYNC_LEN-1:0] sr_q [OSR];
  logic [SYNC_LEN-1:0] cur;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ph_q <= '0;
    else         ph_q <= (ph_q == PW'(OSR-1)) ? '0 : ph_q + 1'b1;
  end

  // one history per sample phase
  for (genvar g = 0; g < OSR; g++) begin : g_ph
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                sr_q[g] <= '0;
      else if (ph_q == PW'(g))    sr_q[g] <= {sample_i, sr_q[g][SYNC_LEN-1:1]};
    end
  end

  assign cur   = {sample_i, sr_q[ph_q][SYNC_LEN-1:1]};
  assign hit_o = en_i && (cur == SYNC_WORD);
endmodule

// File: rtl/adv_ram.sv
module adv_ram #(
  parameter int unsigned DEPTH = 37,
  parameter int unsigned AW    = 6
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [7:0]    wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [7:0]    rdata_o
);
  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
    rdata_o <= mem_q[raddr_i];
  end
endmodule

// File: rtl/adv_uart_tx.sv
module adv_uart_tx #(
  parameter int unsigned CLKS_PER_BAUD = 69
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic [7:0] data_i,
  output logic       busy_o,
  output logic       tx_o
);
  localparam int unsigned CW = (CLKS_PER_BAUD > 1) ? $clog2(CLKS_PER_BAUD) : 1;

  logic [9:0]    sh_q;
  logic [3:0]    nbit_q;
  logic [CW-1:0] cc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '1;
      nbit_q <= '0;
      cc_q   <= '0;
      busy_o <= 1'b0;
    end else if (!busy_o) begin
      if (start_i) begin
        sh_q   <= {1'b1, data_i, 1'b0};
        nbit_q <= '0;
        cc_q   <= '0;
        busy_o <= 1'b1;
      end
    end else if (cc_q == CW'(CLKS_PER_BAUD-1)) begin
      cc_q   <= '0;
      sh_q   <= {1'b1, sh_q[9:1]};
      nbit_q <= nbit_q + 1'b1;
      if (nbit_q == 4'd9) busy_o <= 1'b0;
    end else begin
      cc_q <= cc_q + 1'b1;
    end
  end

  assign tx_o = busy_o ? sh_q[0] : 1'b1;
endmodule

// File: rtl/adv_rx.sv
module adv_rx #(
  parameter int unsigned OSR           = 8,
  parameter int unsigned DEPTH         = 37,
  parameter int unsigned CLKS_PER_BAUD = 69
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sample_i,
  input  logic [5:0] chan_i,
  output logic       uart_tx_o
);
  import adv_pkg::*;
  localparam int unsigned PW = (OSR > 1) ? $clog2(OSR) : 1;
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  adv_state_e  state_q;
  logic [PW-1:0] cnt_q;
  logic [4:0]  nbit_q;
  logic [6:0]  wh_q, wh_nx;
  logic [23:0] crc_q, crc_nx;
  logic [7:0]  sh_q, byte_nx, len_q, idx_q, rd_idx_q;
  logic [1:0]  rd_ph_q;
  logic        hit, stb, d, fb, we, u_start, u_busy;
  logic [7:0]  rd_data;

  adv_sync #(.OSR(OSR)) u_sync (
    .clk_i, .rst_ni, .sample_i, .en_i(state_q == ST_HUNT), .hit_o(hit)
  );

  assign stb     = (state_q inside {ST_HDR, ST_BODY, ST_CRC}) && (cnt_q == PW'(OSR-1));
  assign d       = sample_i ^ wh_q[0];
  assign wh_nx   = {wh_q[0], wh_q[6], wh_q[5], wh_q[4], wh_q[3] ^ wh_q[0], wh_q[2], wh_q[1]};
  assign byte_nx = {d, sh_q[7:1]};
  assign fb      = crc_q[23] ^ d;
  assign crc_nx  = {crc_q[22:0], 1'b0} ^ (fb ? CRC_POLY : 24'h0);
  assign we      = stb && (state_q == ST_BODY) && (nbit_q == 5'd7);
  assign u_start = (state_q == ST_SEND) && (rd_ph_q == 2'd2);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_HUNT;
      cnt_q    <= '0;
      nbit_q   <= '0;
      wh_q     <= '0;
      crc_q    <= CRC_INIT;
      sh_q     <= '0;
      len_q    <= '0;
      idx_q    <= '0;
      rd_idx_q <= '0;
      rd_ph_q  <= '0;
    end else begin
      if (state_q inside {ST_HDR, ST_BODY, ST_CRC})
        cnt_q <= (cnt_q == PW'(OSR-1)) ? '0 : cnt_q + 1'b1;
      if (stb) begin
        wh_q   <= wh_nx;
        crc_q  <= crc_nx;
        sh_q   <= byte_nx;
        nbit_q <= nbit_q + 1'b1;
      end
      unique case (state_q)
        ST_HUNT: if (hit) begin
          state_q <= ST_HDR;
          cnt_q   <= '0;
          nbit_q  <= '0;
          wh_q    <= {1'b1, chan_i};
          crc_q   <= CRC_INIT;
          idx_q   <= '0;
        end
        ST_HDR: if (stb && nbit_q == 5'd15) begin
          len_q  <= byte_nx;
          nbit_q <= '0;
          if (int'(byte_nx) > DEPTH) state_q <= ST_HUNT;
          else if (byte_nx == 8'd0)  state_q <= ST_CRC;
          else                       state_q <= ST_BODY;
        end
        ST_BODY: if (we) begin
          nbit_q <= '0;
          idx_q  <= idx_q + 1'b1;
          if (idx_q + 8'd1 == len_q) state_q <= ST_CRC;
        end
        ST_CRC: if (stb && nbit_q == 5'd23) begin
          rd_idx_q <= '0;
          rd_ph_q  <= '0;
          state_q  <= (crc_nx == 24'h0 && len_q != 8'd0) ? ST_SEND : ST_HUNT;
        end
        ST_SEND: begin
          // address, RAM read latency, then launch
          unique case (rd_ph_q)
            2'd0:    if (!u_busy) rd_ph_q <= 2'd1;
            2'd1:    rd_ph_q <= 2'd2;
            default: begin
              rd_ph_q  <= 2'd0;
              rd_idx_q <= rd_idx_q + 1'b1;
              if (rd_idx_q + 8'd1 == len_q) state_q <= ST_HUNT;
            end
          endcase
        end
        default: state_q <= ST_HUNT;
      endcase
    end
  end

  adv_ram #(.DEPTH(DEPTH), .AW(AW)) u_ram (
    .clk_i,
    .we_i(we),
    .waddr_i(idx_q[AW-1:0]),
    .wdata_i(byte_nx),
    .raddr_i(rd_idx_q[AW-1:0]),
    .rdata_o(rd_data)
  );

  adv_uart_tx #(.CLKS_PER_BAUD(CLKS_PER_BAUD)) u_uart (
    .clk_i, .rst_ni,
    .start_i(u_start),
    .data_i(rd_data),
    .busy_o(u_busy),
    .tx_o(uart_tx_o)
  );
endmodule

// File: rtl/adv_rx_chk.sv
module adv_rx_chk #(
  parameter int unsigned DEPTH = 37
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [2:0] state,
  input logic       hit,
  input logic       we,
  input logic [7:0] widx,
  input logic       u_busy,
  input logic       u_start,
  input logic       tx
);
  import adv_pkg::*;

  // R1
  line_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !u_busy |-> tx);

  // R2
  hit_in_hunt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit |-> (state == 3'(ST_HUNT)));

  // R2
  hit_to_hdr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit |=> (state == 3'(ST_HDR)));

  // R5
  ram_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we |-> (state == 3'(ST_BODY)) && (int'(widx) < DEPTH));

  // R6
  send_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == 3'(ST_SEND)) && ($past(state) != 3'(ST_SEND)) |-> $past(state) == 3'(ST_CRC));

  // R7
  start_free_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    u_start |-> !u_busy);
endmodule

bind adv_rx adv_rx_chk #(.DEPTH(DEPTH)) u_chk (
  .clk_i(clk_i),
  .rst_ni(rst_ni),
  .state(state_q),
  .hit(hit),
  .we(we),
  .widx(idx_q),
  .u_busy(u_busy),
  .u_start(u_start),
  .tx(uart_tx_o)
);

// File: tb/sim_adv_rx.sv
module sim_adv_rx;
  localparam int OSR = 4;
  localparam int DEPTH = 8;
  localparam int CPB = 4;

  logic clk = 0;
  logic rst_n = 0;
  logic smp = 0;
  logic [5:0] chan = 0;
  logic tx;

  int n_tests = 0;
  int n_fail = 0;
  bit done = 0;

  logic [7:0] pay [0:15];
  logic [7:0] cap [0:15];
  int cap_n = 0;
  logic [6:0] w;
  logic [23:0] c;

  always #4 clk = ~clk;

  adv_rx #(.OSR(OSR), .DEPTH(DEPTH), .CLKS_PER_BAUD(CPB)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .sample_i(smp), .chan_i(chan), .uart_tx_o(tx)
  );

  // serial capture
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && tx == 1'b0) begin
        logic [7:0] v;
        repeat (CPB/2) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
          repeat (CPB) @(negedge clk);
          v[i] = tx;
        end
        repeat (CPB) @(negedge clk);
        if (cap_n < 16) cap[cap_n] = v;
        cap_n++;
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic sym(input logic v);
    smp = v;
    repeat (OSR) @(negedge clk);
  endtask

  task automatic raw_byte(input logic [7:0] b);
    for (int i = 0; i < 8; i++) sym(b[i]);
  endtask

  // dewhitening spec applied in reverse: s6'=s0, s2'=s3^s0, rest shift down
  task automatic wsym(input logic b);
    sym(b ^ w[0]);
    w = {w[0], w[6], w[5], w[4], w[3] ^ w[0], w[2], w[1]};
  endtask

  task automatic pdu_byte(input logic [7:0] b);
    for (int i = 0; i < 8; i++) begin
      logic f;
      f = c[23] ^ b[i];
      c = {c[22:0], 1'b0} ^ (f ? 24'h00065B : 24'h0);
      wsym(b[i]);
    end
  endtask

  task automatic send_pkt(input logic [7:0] pre, input logic [31:0] aa,
                          input logic [7:0] len, input int npay,
                          input int off, input bit bad_crc);
    logic [23:0] cs;
    smp = 0;
    repeat (20 + off) @(negedge clk);
    w = {1'b1, chan};
    c = 24'h555555;
    raw_byte(pre);
    for (int i = 0; i < 4; i++) raw_byte(aa[8*i +: 8]);
    pdu_byte(8'h02);
    pdu_byte(len);
    for (int i = 0; i < npay; i++) pdu_byte(pay[i]);
    cs = c;
    if (bad_crc) cs[5] = ~cs[5];
    for (int i = 23; i >= 0; i--) wsym(cs[i]);
    smp = 0;
  endtask

  task automatic run(input string req, input logic [7:0] pre, input logic [31:0] aa,
                     input int len, input int npay, input int off,
                     input bit bad_crc, input int exp_n);
    for (int i = 0; i < npay; i++) pay[i] = 8'(len * 37 + i * 91 + int'(chan) * 13 + 5);
    cap_n = 0;
    send_pkt(pre, aa, 8'(len), npay, off, bad_crc);
    repeat (npay * 10 * CPB + 200) @(negedge clk);
    chk({req, " byte count"}, cap_n, exp_n);
    for (int i = 0; i < exp_n && i < cap_n; i++)
      chk({req, " payload byte"}, int'(cap[i]), int'(pay[i]));
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int chans [4];
    chans = '{0, 17, 37, 39};
    repeat (5) @(negedge clk);
    chk("R1 line high in reset", int'(tx), 1);
    rst_n = 1;
    repeat (100) @(negedge clk);
    chk("R1 line high when idle", int'(tx), 1);

    // R2 R3 R4 R5 R6 R7 R8: every length, phase, several seeds
    foreach (chans[k]) begin
      chan = 6'(chans[k]);
      for (int len = 0; len <= DEPTH; len++)
        run(len == 0 ? "R8" : "R7", 8'hAA, 32'h8E89BED6, len, len,
            (len + k) % OSR, 1'b0, len);
    end

    chan = 6'd5;
    // R6 corrupted CRC discarded
    run("R6", 8'hAA, 32'h8E89BED6, 4, 4, 1, 1'b1, 0);
    // R2 wrong address
    run("R2 address", 8'hAA, 32'h8E89BED7, 4, 4, 2, 1'b0, 0);
    // R2 inverted preamble
    run("R2 preamble", 8'h55, 32'h8E89BED6, 4, 4, 3, 1'b0, 0);
    // R5 length past DEPTH dropped
    run("R5", 8'hAA, 32'h8E89BED6, DEPTH + 1, DEPTH + 1, 0, 1'b0, 0);
    // R3 recovery and odd phase after drops
    run("R3", 8'hAA, 32'h8E89BED6, 3, 3, 3, 1'b0, 3);
    chk("R1 line high after drain", int'(tx), 1);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule